// File: doc/BRIEF.md
# Power-Down Hold Controller

This block sits between the pins of a programmable logic array and the array itself. It lets one dedicated pin freeze the whole array. When a configuration bit turns the feature on and that pin goes high, the controller does four things. It captures every input pin value the array sees. It stops all register clock enables. It holds the data and output-enable values presented to the output pads, and a pad that was high-impedance stays high-impedance. While the hold lasts, later pin activity cannot reach the array.

When the pin drops, the controller stays frozen for a settable number of recovery cycles and then hands live values back. With the feature turned off, the power-down pin is just one more logic input to the array.

The controller is a three-state machine:
- `ST_LIVE`: pins pass through to the array.
- `ST_FROZEN`: the hold is active.
- `ST_RECOVER`: the hold is released but the recovery cycles are still being counted.

Its transitions are:
- `T_FREEZE`: from `ST_LIVE` to `ST_FROZEN`, when the feature is on and the pin is high at a rising edge.
- `T_RELEASE`: from `ST_FROZEN` to `ST_RECOVER`, when the pin is low at an edge.
- `T_REFREEZE`: from `ST_RECOVER` to `ST_FROZEN`, when the pin is high again.
- `T_WAKE`: from `ST_RECOVER` to `ST_LIVE`, once the recovery count is spent.

Top module: `pdhold_ctrl`

## Requirements
- R1: After reset the state is live: `core_din` equals `pin_in`, `pad_dout`/`pad_doe` equal `core_dout`/`core_doe`, and `core_clk_en` is 1 while `pd_pin` is low.
- R2: With `cfg_pd_en` = 0, `core_pd_in` follows `pd_pin`, `core_clk_en` stays 1, and all paths remain live whatever `pd_pin` does.
- R3: With `cfg_pd_en` = 1, `core_pd_in` is 0 at all times.
- R4: With `cfg_pd_en` = 1, `core_clk_en` is 0 in every cycle where `pd_pin` is high. It also stays 0 throughout the frozen and recovery periods.
- R5: `core_din` takes the value of `pin_in` at the first rising edge where `pd_pin` is sampled high. It keeps that value, whatever `pin_in` does, until the hold is released.
- R6: During the hold, `pad_dout` and `pad_doe` keep the values `core_dout` and `core_doe` had at the freezing edge.
- R7: A pad whose `pad_doe` bit was 0 (high-impedance) at the freezing edge keeps that bit at 0 for the whole hold, even if `core_doe` later sets it.
- R8: After the first edge where `pd_pin` is sampled low, values stay held and `core_clk_en` stays 0 for a further `RECOVER_CYC` edges. After the next edge, all paths are live again.
- R9: If `pd_pin` rises again during recovery, the controller returns to the hold without ever releasing. The originally captured values stay in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_pd_en | input | 1 | 1 enables the power-down hold function |
| pd_pin | input | 1 | Power-down pin, active high |
| pin_in | input | IN_W | Raw input and I/O pin values |
| core_dout | input | OUT_W | Output data from the logic array |
| core_doe | input | OUT_W | Output enables from the logic array, 1 drives the pad |
| core_din | output | IN_W | Gated input values to the logic array |
| core_pd_in | output | 1 | Power-down pin as seen by the array (0 when the feature is on) |
| core_clk_en | output | 1 | Enable for all array register clocks |
| pad_dout | output | OUT_W | Data to the output pads |
| pad_doe | output | OUT_W | Enables to the output pads |

## Verification
The hold is exercised with pin, data and enable patterns chosen so that every bit flips between the capture edge and the following cycles. A leaked live value therefore always differs from the captured one. A mixed enable pattern with high-impedance bits shows whether such bits stay at zero or follow the array. Three cases are run: a clean release, a re-assertion in the middle of recovery, and a disabled run with the pin toggling. Together they separate the exact recovery length, release without re-freezing, and the pin's double role as plain input versus masked control.

// File: rtl/pdhold_pkg.sv
package pdhold_pkg;

    typedef enum logic [1:0] {
        ST_LIVE    = 2'd0,
        ST_FROZEN  = 2'd1,
        ST_RECOVER = 2'd2
    } pd_state_e;

endpackage

// File: rtl/pdhold_fsm.sv
module pdhold_fsm
    import pdhold_pkg::*;
#(
    parameter int RECOVER_CYC = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      freeze_req,
    output logic      live_path,
    output logic      clk_en,
    output pd_state_e state
);

    localparam int CNT_W = (RECOVER_CYC < 2) ? 1 : $clog2(RECOVER_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RECOVER_CYC - 1);

    pd_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LIVE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = '0;
        unique case (state_q)
            ST_LIVE: begin
                if (freeze_req) state_d = ST_FROZEN;         // T_FREEZE
            end
            ST_FROZEN: begin
                if (!freeze_req) state_d = ST_RECOVER;       // T_RELEASE
            end
            ST_RECOVER: begin
                if (freeze_req) begin
                    state_d = ST_FROZEN;                     // T_REFREEZE
                end else if (cnt_q == LAST) begin
                    state_d = ST_LIVE;                       // T_WAKE
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_LIVE;
        endcase
    end

    // outputs
    always_comb begin
        live_path = (state_q == ST_LIVE);
        clk_en    = live_path && !freeze_req;
        state     = state_q;
    end

endmodule

// File: rtl/pdhold_capture.sv
module pdhold_capture #(
    parameter int         W        = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         track,
    input  logic [W-1:0] live_val,
    output logic [W-1:0] out_val
);

    logic [W-1:0] held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     held_q <= RST_VAL;
        else if (track) held_q <= live_val;
    end

    always_comb out_val = track ? live_val : held_q;

endmodule

// File: rtl/pdhold_ctrl.sv
module pdhold_ctrl
    import pdhold_pkg::*;
#(
    parameter int IN_W        = 8,
    parameter int OUT_W       = 4,
    parameter int RECOVER_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_pd_en,
    input  logic             pd_pin,
    input  logic [IN_W-1:0]  pin_in,
    input  logic [OUT_W-1:0] core_dout,
    input  logic [OUT_W-1:0] core_doe,
    output logic [IN_W-1:0]  core_din,
    output logic             core_pd_in,
    output logic             core_clk_en,
    output logic [OUT_W-1:0] pad_dout,
    output logic [OUT_W-1:0] pad_doe
);

    localparam int PAD_W = 2 * OUT_W;

    logic      freeze_req;
    logic      live_path;
    pd_state_e state;
    logic [PAD_W-1:0] pad_live, pad_out;

    always_comb begin
        freeze_req = cfg_pd_en && pd_pin;
        core_pd_in = cfg_pd_en ? 1'b0 : pd_pin;
        pad_live   = {core_doe, core_dout};
    end

    pdhold_fsm #(.RECOVER_CYC(RECOVER_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .freeze_req (freeze_req),
        .live_path  (live_path),
        .clk_en     (core_clk_en),
        .state      (state)
    );

    pdhold_capture #(.W(IN_W), .RST_VAL('0)) u_in_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .track    (live_path),
        .live_val (pin_in),
        .out_val  (core_din)
    );

    pdhold_capture #(.W(PAD_W), .RST_VAL('0)) u_pad_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .track    (live_path),
        .live_val (pad_live),
        .out_val  (pad_out)
    );

    always_comb begin
        pad_dout = pad_out[OUT_W-1:0];
        pad_doe  = pad_out[PAD_W-1:OUT_W];
    end

endmodule

// File: rtl/pdhold_ctrl_chk.sv
module pdhold_ctrl_chk #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_pd_en,
    input logic             pd_pin,
    input logic [IN_W-1:0]  pin_in,
    input logic [IN_W-1:0]  core_din,
    input logic             core_pd_in,
    input logic             core_clk_en,
    input logic [OUT_W-1:0] pad_dout,
    input logic [OUT_W-1:0] pad_doe
);

    p_disabled_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_pd_en |-> (core_pd_in == pd_pin) && core_clk_en && (core_din == pin_in));

    p_pd_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_pd_en |-> !core_pd_in);

    p_clk_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_pd_en && pd_pin) |-> !core_clk_en);

    p_in_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_pd_en && pd_pin) && cfg_pd_en && pd_pin)
            |-> $stable(core_din));

    p_pad_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_pd_en && pd_pin) && cfg_pd_en && pd_pin)
            |-> ($stable(pad_dout) && $stable(pad_doe)));

    p_hiz_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_pd_en && pd_pin) && cfg_pd_en && pd_pin)
            |-> ((pad_doe & ~$past(pad_doe)) == '0));

    p_recover_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pd_pin) && !pd_pin && cfg_pd_en && $past(cfg_pd_en))
            |=> !core_clk_en);

endmodule

bind pdhold_ctrl pdhold_ctrl_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_pd_en   (cfg_pd_en),
    .pd_pin      (pd_pin),
    .pin_in      (pin_in),
    .core_din    (core_din),
    .core_pd_in  (core_pd_in),
    .core_clk_en (core_clk_en),
    .pad_dout    (pad_dout),
    .pad_doe     (pad_doe)
);

// File: tb/pdhold_ctrl_tb.sv
module pdhold_ctrl_tb_top;

    localparam int IN_W  = 8;
    localparam int OUT_W = 4;
    localparam int REC   = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_pd_en = 1'b0;
    logic             pd_pin = 1'b0;
    logic [IN_W-1:0]  pin_in = '0;
    logic [OUT_W-1:0] core_dout = '0;
    logic [OUT_W-1:0] core_doe = '0;
    logic [IN_W-1:0]  core_din;
    logic             core_pd_in;
    logic             core_clk_en;
    logic [OUT_W-1:0] pad_dout;
    logic [OUT_W-1:0] pad_doe;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pdhold_ctrl #(.IN_W(IN_W), .OUT_W(OUT_W), .RECOVER_CYC(REC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_pd_en(cfg_pd_en), .pd_pin(pd_pin),
        .pin_in(pin_in), .core_dout(core_dout), .core_doe(core_doe),
        .core_din(core_din), .core_pd_in(core_pd_in), .core_clk_en(core_clk_en),
        .pad_dout(pad_dout), .pad_doe(pad_doe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        step();
        pin_in = 8'h3C; core_dout = 4'hA; core_doe = 4'h6;
        #1;
        chk("R1 din", 32'(core_din), 32'h3C);
        chk("R1 dout", 32'(pad_dout), 32'hA);
        chk("R1 doe", 32'(pad_doe), 32'h6);
        chk("R1 clk_en", 32'(core_clk_en), 32'h1);
    endtask

    task automatic t_disabled();
        step(); cfg_pd_en = 1'b0; pd_pin = 1'b1; pin_in = 8'h11; #1;
        chk("R2 pd_in", 32'(core_pd_in), 32'h1);
        chk("R2 clk_en", 32'(core_clk_en), 32'h1);
        step(); pin_in = 8'hEE; core_dout = 4'h5; #1;
        chk("R2 din live", 32'(core_din), 32'hEE);
        chk("R2 dout live", 32'(pad_dout), 32'h5);
        step(); pd_pin = 1'b0; #1;
        chk("R2 pd_in low", 32'(core_pd_in), 32'h0);
    endtask

    task automatic t_hold();
        step(); cfg_pd_en = 1'b1; pd_pin = 1'b0;
        pin_in = 8'hA5; core_dout = 4'h9; core_doe = 4'hF; #1;
        chk("R3 pd_in low", 32'(core_pd_in), 32'h0);
        step(); pd_pin = 1'b1; #1;
        chk("R4 clk_en same cycle", 32'(core_clk_en), 32'h0);
        chk("R3 pd_in masked", 32'(core_pd_in), 32'h0);
        chk("R5 din still live", 32'(core_din), 32'hA5);
        step(); pin_in = 8'h5A; core_dout = 4'h6; core_doe = 4'h0; #1;
        chk("R5 din held", 32'(core_din), 32'hA5);
        chk("R6 dout held", 32'(pad_dout), 32'h9);
        chk("R6 doe held", 32'(pad_doe), 32'hF);
        for (int i = 0; i < 3; i++) begin
            step(); pin_in = ~pin_in; core_dout = ~core_dout; #1;
            chk("R5 din held long", 32'(core_din), 32'hA5);
            chk("R4 clk_en held", 32'(core_clk_en), 32'h0);
        end
    endtask

    task automatic t_hiz_and_recover();
        step(); pd_pin = 1'b0; pin_in = 8'h77; core_dout = 4'h3; core_doe = 4'h5;
        for (int i = 0; i <= REC + 1; i++) step();
        #1;
        chk("R8 live before hiz", 32'(pad_doe), 32'h5);
        step(); pd_pin = 1'b1;
        step(); core_doe = 4'hF; core_dout = 4'hC; pin_in = 8'h88; #1;
        chk("R7 hiz kept", 32'(pad_doe), 32'h5);
        chk("R6 dout held", 32'(pad_dout), 32'h3);
        step(); pd_pin = 1'b0; #1;
        chk("R8 held at drop", 32'(pad_doe), 32'h5);
        for (int i = 1; i <= REC; i++) begin
            step(); #1;
            chk("R8 held in recovery", 32'(pad_doe), 32'h5);
            chk("R8 clk_en low in recovery", 32'(core_clk_en), 32'h0);
            chk("R8 din held in recovery", 32'(core_din), 32'h77);
        end
        step(); #1;
        chk("R8 doe live", 32'(pad_doe), 32'hF);
        chk("R8 din live", 32'(core_din), 32'h88);
        chk("R8 clk_en back", 32'(core_clk_en), 32'h1);
    endtask

    task automatic t_reassert();
        step(); pin_in = 8'h3C; pd_pin = 1'b1;
        step(); pin_in = 8'h00; #1;
        chk("R9 frozen", 32'(core_din), 32'h3C);
        step(); pd_pin = 1'b0;
        step(); step();
        pd_pin = 1'b1; pin_in = 8'hC3;
        for (int i = 0; i < REC + 3; i++) begin
            step(); #1;
            chk("R9 kept original", 32'(core_din), 32'h3C);
            chk("R9 clk_en low", 32'(core_clk_en), 32'h0);
        end
        step(); pd_pin = 1'b0;
        for (int i = 0; i <= REC; i++) step();
        #1;
        chk("R9 released", 32'(core_din), 32'hC3);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disabled();
        t_hold();
        t_hiz_and_recover();
        t_reassert();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule